// File: doc/BRIEF.md
# Masked Interrupt Pending Controller

This block gathers up to 32 level-sensitive interrupt lines into one request for the processor core. A line that is high at a clock edge latches a pending flag in a status register. The flag stays set until software clears it. A mask register chooses which pending flags may reach the core. The single request output is high whenever a pending flag is also enabled.

Software reaches both registers through a simple special-register port. The port has a write strobe, an address, write data and combinational read data. Each address is formed as (group << 11) + index. The mask uses group 9, index 0, and the status register uses group 9, index 2. A write to the status register only clears flags. A write to the mask takes effect in the request on the very next edge. Priority and vector selection are left to the core.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While reset is held, and right after it is released, the mask, the status and `irq_req` are all zero.
- R2: A write to address 0x4800 (group 9, index 0) stores the full 32-bit word in the mask. A read of 0x4800 returns the mask.
- R3: A read of address 0x4802 (group 9, index 2) returns the 32-bit status, with bit i being the pending flag of line i.
- R4: If line i is high at a rising edge, status bit i is 1 after that edge. The bit stays 1 after the line falls, until software clears it.
- R5: A write to 0x4802 clears each status bit whose data bit is 1 and leaves every other bit unchanged. Such a write never sets a bit.
- R6: If line i is high in the same cycle that a status write clears bit i, the bit ends up set.
- R7: `irq_req` is registered. After every rising edge it equals the OR over all bits of (status AND mask) as they stand after that edge. So it rises one cycle after the line or write that causes it.
- R8: A mask write re-evaluates the request at once. Clearing the only enabled pending bit drops `irq_req` after that edge, and enabling a pending bit raises it after that edge.
- R9: Writes to any address other than 0x4800 and 0x4802 change neither register. Reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | 32 | Level interrupt inputs, one per status bit |
| reg_wr | input | 1 | Write strobe for the special-register port |
| reg_addr | input | 16 | Special-register address, (group << 11) + index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_req | output | 1 | Registered interrupt request to the core |

## Verification
The bound checker checks several rules on every cycle after reset:
- the request always matches the masked pending set;
- a high line always leaves its flag set;
- a status write never sets a bit that no line set;
- the mask takes exactly the written word;
- both registers hold still when nothing touches them.

Only the bench scenarios can show the behaviour seen at the ports:
- the address decode, including the neighbouring index 1 and a different group;
- the read path;
- the exact cycle in which the request rises or falls after a line pulse or a mask write;
- a line that goes high in the same cycle as a clear of its own bit.

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int NUM_LINES   = 32,
  parameter int ADDR_W      = 16,
  parameter int GROUP_SHIFT = 11,
  parameter int GROUP       = 9,
  parameter int MASK_INDEX  = 0,
  parameter int STAT_INDEX  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [NUM_LINES-1:0] reg_wdata,
  output logic [NUM_LINES-1:0] reg_rdata,
  output logic                 irq_req
);

  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'((GROUP << GROUP_SHIFT) + MASK_INDEX);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'((GROUP << GROUP_SHIFT) + STAT_INDEX);

  logic [NUM_LINES-1:0] mask_q, stat_q, mask_d, stat_d, clr_bits;
  logic                 hit_mask, hit_stat;

  assign hit_mask = reg_addr == MASK_ADDR;
  assign hit_stat = reg_addr == STAT_ADDR;
  assign clr_bits = (reg_wr && hit_stat) ? reg_wdata : '0;

  assign mask_d = (reg_wr && hit_mask) ? reg_wdata : mask_q;
  assign stat_d = (stat_q & ~clr_bits) | irq_lines;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      stat_q  <= '0;
      irq_req <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      stat_q  <= stat_d;
      irq_req <= |(stat_d & mask_d);
    end
  end

  assign reg_rdata = hit_mask ? mask_q :
                     hit_stat ? stat_q : '0;

endmodule

// File: rtl/irq_mask_ctrl_sva.sv
module irq_mask_ctrl_sva #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic                 reg_wr,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [NUM_LINES-1:0] reg_wdata,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] stat_q,
  input logic                 irq_req
);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(16'h4800);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(16'h4802);

  a_r2_mask_store: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == MASK_A) |=> mask_q == $past(reg_wdata));

  a_r4_line_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lines != '0) |=> ((stat_q & $past(irq_lines)) == $past(irq_lines)));

  a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == STAT_A) |=> ((stat_q & ~($past(stat_q) | $past(irq_lines))) == '0));

  a_r7_req_matches: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == |(stat_q & mask_q));

  a_r9_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && irq_lines == '0) |=> ($stable(stat_q) && $stable(mask_q)));
endmodule

bind irq_mask_ctrl irq_mask_ctrl_sva #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mask_q(mask_q),
  .stat_q(stat_q), .irq_req(irq_req)
);

// File: tb/irq_mask_ctrl_bench.sv
module irq_mask_ctrl_bench;
  localparam logic [15:0] A_MASK = 16'h4800;
  localparam logic [15:0] A_STAT = 16'h4802;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  irq_mask_ctrl u_irq_mask_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] l);
    @(negedge clk);
    irq_lines = l;
    @(negedge clk);
    irq_lines = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 req in reset", {31'b0, irq_req}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(A_MASK, v); check("R1 mask after reset", v, 32'h0);
    rd(A_STAT, v); check("R1 status after reset", v, 32'h0);
    check("R1 req after reset", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_mask_rw();
    logic [31:0] v;
    wr(A_MASK, 32'hA5C3_0F1E);
    rd(A_MASK, v); check("R2 mask readback", v, 32'hA5C3_0F1E);
    wr(A_MASK, 32'h0);
    rd(A_MASK, v); check("R2 mask rewritten", v, 32'h0);
  endtask

  task automatic t_latch();
    logic [31:0] v;
    pulse(32'h8000_0011);
    rd(A_STAT, v); check("R4 R3 status latched after line fell", v, 32'h8000_0011);
    check("R7 masked-off no request", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(A_STAT, 32'h0000_0010);
    rd(A_STAT, v); check("R5 clear one bit", v, 32'h8000_0001);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R5 zero write keeps bits", v, 32'h8000_0001);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R5 clear all", v, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    pulse(32'h0000_0060);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h0000_0060; irq_lines = 32'h0000_0020;
    @(negedge clk);
    reg_wr = 1'b0; irq_lines = '0;
    rd(A_STAT, v); check("R6 set beats clear", v, 32'h0000_0020);
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_req_timing();
    logic [31:0] v;
    wr(A_MASK, 32'h0000_0100);
    @(negedge clk);
    irq_lines = 32'h0000_0100;
    #1 check("R7 no request before edge", {31'b0, irq_req}, 32'h0);
    @(posedge clk); #1;
    check("R7 request one edge after line", {31'b0, irq_req}, 32'h1);
    @(negedge clk); irq_lines = '0;
    wr(A_STAT, 32'h0000_0100);
    check("R7 request drops after clear", {31'b0, irq_req}, 32'h0);
    rd(A_STAT, v); check("R7 status empty", v, 32'h0);
  endtask

  task automatic t_mask_reval();
    pulse(32'h0000_0004);
    check("R8 pending but masked", {31'b0, irq_req}, 32'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_MASK; reg_wdata = 32'h0000_0004;
    @(posedge clk); #1;
    check("R8 mask enable raises request", {31'b0, irq_req}, 32'h1);
    @(negedge clk);
    reg_wdata = 32'h0000_0000;
    @(posedge clk); #1;
    check("R8 mask disable drops request", {31'b0, irq_req}, 32'h0);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic t_other_addr();
    logic [31:0] v;
    wr(16'h4801, 32'hFFFF_FFFF);
    wr(16'h2800, 32'hFFFF_FFFF);
    wr(16'h2802, 32'hFFFF_FFFF);
    rd(A_MASK, v); check("R9 mask untouched", v, 32'h0);
    rd(A_STAT, v); check("R9 status untouched", v, 32'h0000_0004);
    rd(16'h4801, v); check("R9 unmapped read zero", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_mask_rw();
    t_latch();
    t_clear();
    t_set_wins();
    t_req_timing();
    t_mask_reval();
    t_other_addr();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule